// File: doc/BRIEF.md
# Bus Break Condition Unit

This block monitors a processor's bus activity cycle by cycle and raises a break request when a programmed condition holds. There are three condition channels, each with its own settings. A channel can compare the main bus address or the program counter against a value. It can compare the data bus at a chosen access size. It can qualify on read or write direction and on the bus type. It can match the second (X/Y) bus on its address or its data. It can also react to accesses into the internal I/O region or to the execution of a TLB-load instruction.

Each qualifier has its own enable bit. A channel hits when at least one qualifier is enabled and every enabled qualifier is satisfied in the same cycle. A pass counter holds the break back until the channel has hit the programmed number of times. The break then appears as a one-cycle pulse, and the channel stays quiet until it is re-armed by a count write. Configuration is written through a simple write port that selects a channel, a register index and a data word.

Top module: `bus_break_unit`

## Requirements
- R1: The three channels are independent. A write with `cfg_we` high goes to channel `cfg_chan` (0 to 2) and register `cfg_reg`: 0 is control, 1 is address value, 2 is data value, 3 is X/Y value, and 4 is pass count, which also arms the channel. `brk[i]` belongs to channel i only.
- R2: The address qualifier (control bit 0) compares either `bus_addr` in a cycle with `bus_valid`, or `pc_addr` in a cycle with `pc_step`. Control bit 1 selects the source: 0 for the bus, 1 for the PC.
- R3: The data qualifier (control bit 2) needs `bus_valid` and `bus_size` equal to control bits 4:3 (0 byte, 1 word, 2 longword, 3 never matches). The bus is big-endian. A byte compares lane `bus_addr[1:0]` (lane 0 is `bus_data[31:24]`) with value bits 7:0. A word compares `bus_data[31:16]` when `bus_addr[1]` is 0, otherwise `bus_data[15:0]`, against value bits 15:0. A longword compares all 32 bits.
- R4: The X/Y qualifier (control bit 12) needs `xy_valid`. It compares `xy_addr` when control bit 13 is 0, or `xy_data` when it is 1, against the X/Y value register.
- R5: The direction qualifier (control bit 5) needs `bus_valid` and `bus_rd` equal to control bit 6 (1 means read).
- R6: The bus-type qualifier (control bit 7) needs `bus_valid` and uses control bits 9:8 to choose the accepted values of `bus_kind` (0 cached fetch, 1 cached data, 2 uncached or DMA). Select 0 accepts kinds 0 and 1, select 1 accepts kind 1, select 2 accepts kind 2, and select 3 accepts nothing.
- R7: The I/O qualifier (control bit 10) needs `bus_valid` and `(bus_addr & IO_MASK) == IO_BASE` (defaults: mask 0xFF000000, base 0xA4000000).
- R8: The TLB-load qualifier (control bit 11) is satisfied in a cycle with `tlb_load` high.
- R9: A channel hits only when at least one qualifier is enabled and all enabled qualifiers hold in the same cycle. With no qualifier enabled, the channel never breaks.
- R10: An armed channel counts its hits. On the hit that brings the loaded count to one, `brk[i]` is high for exactly one cycle, in the cycle after that hit. A count of 0 behaves like 1.
- R11: After a break the channel ignores further hits until a new count write. If a count write and a hit land in the same cycle, the write wins: the counter reloads and that hit is not counted.
- R12: During reset and after it, all channels are disarmed and `brk` is 0 until a count write arms a channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Main bus cycle present this clock |
| bus_addr | input | 32 | Main bus address |
| bus_data | input | 32 | Main bus data |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2 longword |
| bus_rd | input | 1 | 1 for read, 0 for write |
| bus_kind | input | 2 | 0 cached fetch, 1 cached data, 2 uncached/DMA |
| pc_step | input | 1 | Instruction issued, `pc_addr` valid |
| pc_addr | input | 32 | Program counter value |
| xy_valid | input | 1 | X/Y bus cycle present |
| xy_addr | input | 32 | X/Y bus address |
| xy_data | input | 32 | X/Y bus data |
| tlb_load | input | 1 | TLB-load instruction executes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 2 | Channel index |
| cfg_reg | input | 3 | Register index |
| cfg_wdata | input | 32 | Configuration write data |
| brk | output | 3 | Per-channel break pulse |

## Verification
The assertions assume that only the listed event inputs (`bus_valid`, `pc_step`, `xy_valid`, `tlb_load`) can produce a hit, and that a channel cannot be re-armed and break at the same edge. They also assume `cfg_chan` stays below 3 whenever `cfg_we` is high. The stimulus keeps to these limits. It drives every input at the falling edge, holds each event for one cycle, and returns all inputs to zero between events. It writes only the five defined register indices of existing channels.

// File: rtl/bbu_pkg.sv
package bbu_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_AVAL = 3'd1,
    REG_DVAL = 3'd2,
    REG_XVAL = 3'd3,
    REG_CNT  = 3'd4
  } reg_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } size_e;

  // Control word: bit 0 is a_en, bit 13 is xy_dat.
  typedef struct packed {
    logic       xy_dat;
    logic       xy_en;
    logic       tlb_en;
    logic       io_en;
    logic [1:0] k_sel;
    logic       k_en;
    logic       dir_rd;
    logic       dir_en;
    logic [1:0] d_size;
    logic       d_en;
    logic       a_pc;
    logic       a_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/bbu_chan_cfg.sv
module bbu_chan_cfg
  import bbu_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic [2:0]    reg_idx,
  input  logic [DW-1:0] wdata,
  output ctrl_t         ctrl,
  output logic [AW-1:0] aval,
  output logic [DW-1:0] dval,
  output logic [AW-1:0] xval,
  output logic          arm,
  output logic [CW-1:0] cnt_ld
);
  ctrl_t         ctrl_q, ctrl_n;
  logic [AW-1:0] aval_q, aval_n, xval_q, xval_n;
  logic [DW-1:0] dval_q, dval_n;

  always_comb begin
    ctrl_n = ctrl_q;
    aval_n = aval_q;
    dval_n = dval_q;
    xval_n = xval_q;
    if (sel) begin
      case (reg_idx)
        REG_CTRL: ctrl_n = ctrl_t'(wdata[CTRL_W-1:0]);
        REG_AVAL: aval_n = wdata[AW-1:0];
        REG_DVAL: dval_n = wdata;
        REG_XVAL: xval_n = wdata[AW-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      aval_q <= '0;
      dval_q <= '0;
      xval_q <= '0;
    end else if (sel) begin
      ctrl_q <= ctrl_n;
      aval_q <= aval_n;
      dval_q <= dval_n;
      xval_q <= xval_n;
    end
  end

  assign ctrl   = ctrl_q;
  assign aval   = aval_q;
  assign dval   = dval_q;
  assign xval   = xval_q;
  assign arm    = sel && (reg_idx == REG_CNT);
  assign cnt_ld = wdata[CW-1:0];
endmodule

// File: rtl/bbu_match.sv
module bbu_match
  import bbu_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter logic [31:0] IO_BASE = 32'hA400_0000,
  parameter logic [31:0] IO_MASK = 32'hFF00_0000
) (
  input  ctrl_t         ctrl,
  input  logic [AW-1:0] aval,
  input  logic [DW-1:0] dval,
  input  logic [AW-1:0] xval,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic [1:0]    bus_size,
  input  logic          bus_rd,
  input  logic [1:0]    bus_kind,
  input  logic          pc_step,
  input  logic [AW-1:0] pc_addr,
  input  logic          xy_valid,
  input  logic [AW-1:0] xy_addr,
  input  logic [DW-1:0] xy_data,
  input  logic          tlb_load,
  output logic          hit
);
  logic [7:0]  lane_b;
  logic [15:0] lane_h;
  logic        data_eq, kind_eq;
  logic        a_ok, d_ok, dir_ok, k_ok, io_ok, tlb_ok, xy_ok, any_en;

  // Big-endian lane pick: the lowest address holds the most significant byte.
  always_comb begin
    case (bus_addr[1:0])
      2'd0:    lane_b = bus_data[31:24];
      2'd1:    lane_b = bus_data[23:16];
      2'd2:    lane_b = bus_data[15:8];
      default: lane_b = bus_data[7:0];
    endcase
    lane_h = bus_addr[1] ? bus_data[15:0] : bus_data[31:16];
    case (size_e'(ctrl.d_size))
      SZ_BYTE: data_eq = (lane_b == dval[7:0]);
      SZ_WORD: data_eq = (lane_h == dval[15:0]);
      SZ_LONG: data_eq = (bus_data == dval);
      default: data_eq = 1'b0;
    endcase
    case (ctrl.k_sel)
      2'd0:    kind_eq = (bus_kind == 2'd0) || (bus_kind == 2'd1);
      2'd1:    kind_eq = (bus_kind == 2'd1);
      2'd2:    kind_eq = (bus_kind == 2'd2);
      default: kind_eq = 1'b0;
    endcase
  end

  always_comb begin
    a_ok   = !ctrl.a_en || (ctrl.a_pc ? (pc_step && (pc_addr == aval))
                                      : (bus_valid && (bus_addr == aval)));
    d_ok   = !ctrl.d_en || (bus_valid && (bus_size == ctrl.d_size) && data_eq);
    dir_ok = !ctrl.dir_en || (bus_valid && (bus_rd == ctrl.dir_rd));
    k_ok   = !ctrl.k_en || (bus_valid && kind_eq);
    io_ok  = !ctrl.io_en ||
             (bus_valid && ((32'(bus_addr) & IO_MASK) == IO_BASE));
    tlb_ok = !ctrl.tlb_en || tlb_load;
    xy_ok  = !ctrl.xy_en ||
             (xy_valid && (ctrl.xy_dat ? (xy_data == DW'(xval)) : (xy_addr == xval)));
    any_en = ctrl.a_en || ctrl.d_en || ctrl.dir_en || ctrl.k_en ||
             ctrl.io_en || ctrl.tlb_en || ctrl.xy_en;
    hit    = any_en && a_ok && d_ok && dir_ok && k_ok && io_ok && tlb_ok && xy_ok;
  end
endmodule

// File: rtl/bbu_pass_cnt.sv
module bbu_pass_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [CW-1:0] cnt_ld,
  input  logic          hit,
  output logic          brk
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic          armed_q, armed_n;
  logic          fire;

  always_comb begin
    cnt_n   = cnt_q;
    armed_n = armed_q;
    fire    = 1'b0;
    if (arm) begin
      cnt_n   = cnt_ld;
      armed_n = 1'b1;
    end else if (armed_q && hit) begin
      if (cnt_q <= CW'(1)) begin
        fire    = 1'b1;
        armed_n = 1'b0;
      end else begin
        cnt_n = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      brk     <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      armed_q <= armed_n;
      brk     <= fire;
    end
  end
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import bbu_pkg::*;
#(
  parameter int unsigned NCH     = 3,
  parameter int unsigned AW      = 32,
  parameter int unsigned CW      = 16,
  parameter logic [31:0] IO_BASE = 32'hA400_0000,
  parameter logic [31:0] IO_MASK = 32'hFF00_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_valid,
  input  logic [AW-1:0]           bus_addr,
  input  logic [DW-1:0]           bus_data,
  input  logic [1:0]              bus_size,
  input  logic                    bus_rd,
  input  logic [1:0]              bus_kind,
  input  logic                    pc_step,
  input  logic [AW-1:0]           pc_addr,
  input  logic                    xy_valid,
  input  logic [AW-1:0]           xy_addr,
  input  logic [DW-1:0]           xy_data,
  input  logic                    tlb_load,
  input  logic                    cfg_we,
  input  logic [$clog2(NCH)-1:0]  cfg_chan,
  input  logic [2:0]              cfg_reg,
  input  logic [DW-1:0]           cfg_wdata,
  output logic [NCH-1:0]          brk
);
  localparam int unsigned CHW = $clog2(NCH);

  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    ctrl_t         ctrl;
    logic [AW-1:0] aval, xval;
    logic [DW-1:0] dval;
    logic          sel, arm, hit;
    logic [CW-1:0] cnt_ld;

    assign sel = cfg_we && (cfg_chan == CHW'(ch));

    bbu_chan_cfg #(.AW(AW), .CW(CW)) u_cfg (
      .clk(clk), .rst_n(rst_sync), .sel(sel), .reg_idx(cfg_reg),
      .wdata(cfg_wdata), .ctrl(ctrl), .aval(aval), .dval(dval),
      .xval(xval), .arm(arm), .cnt_ld(cnt_ld)
    );

    bbu_match #(.AW(AW), .IO_BASE(IO_BASE), .IO_MASK(IO_MASK)) u_match (
      .ctrl(ctrl), .aval(aval), .dval(dval), .xval(xval),
      .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
      .bus_size(bus_size), .bus_rd(bus_rd), .bus_kind(bus_kind),
      .pc_step(pc_step), .pc_addr(pc_addr), .xy_valid(xy_valid),
      .xy_addr(xy_addr), .xy_data(xy_data), .tlb_load(tlb_load), .hit(hit)
    );

    bbu_pass_cnt #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_sync), .arm(arm), .cnt_ld(cnt_ld),
      .hit(hit), .brk(brk[ch])
    );
  end
endmodule

// File: rtl/bbu_checker.sv
module bbu_checker
  import bbu_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         brk,
  input logic                   bus_valid,
  input logic                   pc_step,
  input logic                   xy_valid,
  input logic                   tlb_load,
  input logic                   cfg_we,
  input logic [$clog2(NCH)-1:0] cfg_chan,
  input logic [2:0]             cfg_reg
);
  localparam int unsigned CHW = $clog2(NCH);

  // R12: outputs stay low while reset is applied.
  always @(posedge clk) begin
    if (!rst_n) begin
      p_quiet_in_reset_r12: assert (brk == '0)
        else $error("brk active during reset");
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R10: a break lasts exactly one cycle.
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      brk[i] |=> !brk[i]);

    // R9: a break needs an event input in the preceding cycle.
    p_needs_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
      brk[i] |-> $past(bus_valid || pc_step || xy_valid || tlb_load));

    // R11: a count write to this channel suppresses a break at that edge.
    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (cfg_chan == CHW'(i)) && (cfg_reg == REG_CNT)) |=> !brk[i]);
  end
endmodule

bind bus_break_unit bbu_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .brk(brk), .bus_valid(bus_valid),
  .pc_step(pc_step), .xy_valid(xy_valid), .tlb_load(tlb_load),
  .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_reg(cfg_reg)
);

// File: tb/bus_break_unit_tb.sv
module bus_break_unit_tb;
  localparam logic [15:0] A_EN   = 16'h0001;
  localparam logic [15:0] A_PC   = 16'h0002;
  localparam logic [15:0] D_EN   = 16'h0004;
  localparam logic [15:0] SZ_W   = 16'h0008;
  localparam logic [15:0] SZ_L   = 16'h0010;
  localparam logic [15:0] DIR_EN = 16'h0020;
  localparam logic [15:0] DIR_RD = 16'h0040;
  localparam logic [15:0] K_EN   = 16'h0080;
  localparam logic [15:0] KS1    = 16'h0100;
  localparam logic [15:0] KS2    = 16'h0200;
  localparam logic [15:0] IO_EN  = 16'h0400;
  localparam logic [15:0] TLB_EN = 16'h0800;
  localparam logic [15:0] XY_EN  = 16'h1000;
  localparam logic [15:0] XY_DAT = 16'h2000;

  typedef struct packed {
    logic [7:0]  req;
    logic [15:0] ctrl;
    logic [31:0] aval;
    logic [31:0] dval;
    logic [31:0] baddr;
    logic [31:0] bdata;
    logic [1:0]  bsize;
    logic        brd;
    logic [1:0]  bkind;
    logic        exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'd2, A_EN, 32'h1000_0004, 32'h0, 32'h1000_0004, 32'h0, 2'd2, 1'b1, 2'd1, 1'b1},        // R2 hit
    '{8'd2, A_EN, 32'h1000_0004, 32'h0, 32'h1000_0008, 32'h0, 2'd2, 1'b1, 2'd1, 1'b0},        // R2 miss
    '{8'd3, D_EN, 32'h0, 32'hA5, 32'h1000_0001, 32'h00A5_0000, 2'd0, 1'b1, 2'd1, 1'b1},       // R3 byte lane 1
    '{8'd3, D_EN, 32'h0, 32'hA5, 32'h1000_0001, 32'hA500_0000, 2'd0, 1'b1, 2'd1, 1'b0},       // R3 wrong lane
    '{8'd3, D_EN|SZ_W, 32'h0, 32'h1234, 32'h1000_0002, 32'hFFFF_1234, 2'd1, 1'b1, 2'd1, 1'b1}, // R3 low word
    '{8'd3, D_EN|SZ_W, 32'h0, 32'h1234, 32'h1000_0002, 32'hFFFF_1234, 2'd2, 1'b1, 2'd1, 1'b0}, // R3 size differs
    '{8'd3, D_EN|SZ_L, 32'h0, 32'hDEAD_BEEF, 32'h1000_0000, 32'hDEAD_BEEF, 2'd2, 1'b0, 2'd1, 1'b1}, // R3 long
    '{8'd5, DIR_EN|DIR_RD, 32'h0, 32'h0, 32'h1000_0000, 32'h0, 2'd2, 1'b0, 2'd1, 1'b0},      // R5 write vs read
    '{8'd5, DIR_EN|DIR_RD, 32'h0, 32'h0, 32'h1000_0000, 32'h0, 2'd2, 1'b1, 2'd1, 1'b1},      // R5 read
    '{8'd6, K_EN|KS1, 32'h0, 32'h0, 32'h1000_0000, 32'h0, 2'd2, 1'b1, 2'd0, 1'b0},           // R6 data-only vs fetch
    '{8'd6, K_EN, 32'h0, 32'h0, 32'h1000_0000, 32'h0, 2'd2, 1'b1, 2'd1, 1'b1},               // R6 cached all
    '{8'd6, K_EN|KS2, 32'h0, 32'h0, 32'h1000_0000, 32'h0, 2'd2, 1'b1, 2'd2, 1'b1},           // R6 uncached
    '{8'd6, K_EN, 32'h0, 32'h0, 32'h1000_0000, 32'h0, 2'd2, 1'b1, 2'd2, 1'b0},               // R6 cached vs uncached
    '{8'd7, IO_EN, 32'h0, 32'h0, 32'hA400_1234, 32'h0, 2'd2, 1'b1, 2'd1, 1'b1},              // R7 in region
    '{8'd7, IO_EN, 32'h0, 32'h0, 32'hA500_1234, 32'h0, 2'd2, 1'b1, 2'd1, 1'b0},              // R7 outside
    '{8'd9, A_EN|DIR_EN, 32'h1000_0004, 32'h0, 32'h1000_0004, 32'h0, 2'd2, 1'b1, 2'd1, 1'b0} // R9 AND fails
  };

  logic        clk, rst_n;
  logic        bus_valid, bus_rd, pc_step, xy_valid, tlb_load, cfg_we;
  logic [31:0] bus_addr, bus_data, pc_addr, xy_addr, xy_data, cfg_wdata;
  logic [1:0]  bus_size, bus_kind, cfg_chan;
  logic [2:0]  cfg_reg;
  logic [2:0]  brk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bus_break_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_size(bus_size), .bus_rd(bus_rd),
    .bus_kind(bus_kind), .pc_step(pc_step), .pc_addr(pc_addr),
    .xy_valid(xy_valid), .xy_addr(xy_addr), .xy_data(xy_data),
    .tlb_load(tlb_load), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .brk(brk)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s brk actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic clr();
    bus_valid = 0; bus_addr = '0; bus_data = '0; bus_size = '0; bus_rd = 0;
    bus_kind = '0; pc_step = 0; pc_addr = '0; xy_valid = 0; xy_addr = '0;
    xy_data = '0; tlb_load = 0; cfg_we = 0; cfg_chan = '0; cfg_reg = '0;
    cfg_wdata = '0;
  endtask

  task automatic wr(input int ch, input int r, input logic [31:0] d);
    cfg_we = 1; cfg_chan = 2'(ch); cfg_reg = 3'(r); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic prog(input int ch, input logic [15:0] c, input logic [31:0] a,
                      input logic [31:0] d, input logic [31:0] x, input logic [31:0] n);
    wr(ch, 0, {16'h0, c});
    wr(ch, 1, a);
    wr(ch, 2, d);
    wr(ch, 3, x);
    wr(ch, 4, n);
  endtask

  task automatic bcyc(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                      input logic rd, input logic [1:0] k);
    bus_valid = 1; bus_addr = a; bus_data = d; bus_size = sz; bus_rd = rd; bus_kind = k;
    @(negedge clk);
    clr();
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clr();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R12 during reset", brk, 3'b000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R12 after reset", brk, 3'b000);

    // R12: configured but never armed
    wr(0, 0, {16'h0, A_EN}); wr(0, 1, 32'h1000_0004);
    bcyc(32'h1000_0004, 0, 2, 1, 1);
    chk("R12 unarmed", brk, 3'b000);

    for (int i = 0; i < NV; i++) begin
      prog(0, VECS[i].ctrl, VECS[i].aval, VECS[i].dval, 32'h0, 32'd1);
      bcyc(VECS[i].baddr, VECS[i].bdata, VECS[i].bsize, VECS[i].brd, VECS[i].bkind);
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), brk, {2'b00, VECS[i].exp});
      idle();
    end

    // R2: PC source
    prog(0, A_EN|A_PC, 32'h0000_2000, 0, 0, 1);
    bcyc(32'h0000_2000, 0, 2, 1, 0);
    chk("R2 pc source ignores bus", brk, 3'b000);
    pc_step = 1; pc_addr = 32'h0000_2000; @(negedge clk); clr();
    chk("R2 pc match", brk, 3'b001);
    idle();

    // R4: X/Y bus
    prog(0, XY_EN, 0, 0, 32'h55, 1);
    xy_valid = 1; xy_addr = 32'h55; @(negedge clk); clr();
    chk("R4 xy addr", brk, 3'b001);
    idle();
    prog(0, XY_EN|XY_DAT, 0, 0, 32'h55, 1);
    xy_valid = 1; xy_addr = 32'h55; xy_data = 32'h0; @(negedge clk); clr();
    chk("R4 xy data select ignores addr", brk, 3'b000);
    xy_valid = 1; xy_data = 32'h55; @(negedge clk); clr();
    chk("R4 xy data", brk, 3'b001);
    idle();

    // R8: TLB load
    prog(0, TLB_EN, 0, 0, 0, 1);
    tlb_load = 1; @(negedge clk); clr();
    chk("R8 tlb load", brk, 3'b001);
    idle();

    // R9: nothing enabled
    prog(0, 16'h0, 0, 0, 0, 1);
    tlb_load = 1; pc_step = 1; xy_valid = 1;
    bcyc(32'h0, 0, 2, 1, 0);
    chk("R9 no enables", brk, 3'b000);

    // R10: count of three, single pulse
    prog(0, A_EN, 32'h1000_0004, 0, 0, 3);
    bcyc(32'h1000_0004, 0, 2, 1, 1); chk("R10 hit 1 of 3", brk, 3'b000);
    bcyc(32'h1000_0004, 0, 2, 1, 1); chk("R10 hit 2 of 3", brk, 3'b000);
    bcyc(32'h1000_0004, 0, 2, 1, 1); chk("R10 hit 3 of 3", brk, 3'b001);
    idle(); chk("R10 one cycle", brk, 3'b000);

    // R11: idle after break until rearmed
    bcyc(32'h1000_0004, 0, 2, 1, 1); chk("R11 ignored after break", brk, 3'b000);
    wr(0, 4, 0);
    bcyc(32'h1000_0004, 0, 2, 1, 1); chk("R10 count zero fires at once", brk, 3'b001);
    idle();
    // R11: write and hit together
    wr(0, 4, 1);
    cfg_we = 1; cfg_chan = 0; cfg_reg = 3'd4; cfg_wdata = 32'd1;
    bus_valid = 1; bus_addr = 32'h1000_0004; bus_size = 2; bus_rd = 1; bus_kind = 1;
    @(negedge clk); clr();
    chk("R11 write wins", brk, 3'b000);
    bcyc(32'h1000_0004, 0, 2, 1, 1); chk("R11 reloaded count", brk, 3'b001);
    idle();

    // R1: channels independent
    prog(0, A_EN, 32'h1000_0004, 0, 0, 1);
    prog(1, A_EN, 32'h2000_0000, 0, 0, 1);
    prog(2, A_EN, 32'h2000_0000, 0, 0, 2);
    bcyc(32'h2000_0000, 0, 2, 1, 1); chk("R1 channel 1 only", brk, 3'b010);
    bcyc(32'h2000_0000, 0, 2, 1, 1); chk("R1 channel 2 second hit", brk, 3'b100);
    bcyc(32'h1000_0004, 0, 2, 1, 1); chk("R1 channel 0", brk, 3'b001);
    idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule